// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches up to 64 general-purpose input pins and turns edges on them into interrupt events. Each pin passes through a clock-domain synchroniser; a per-pin polarity bit then picks whether a rising or a falling transition counts as an event. Detected events latch into a status word that software clears by writing ones. A per-pin enable word masks which latched events may raise the single, registered, active-high request sent to the parent interrupt controller. A per-pin wake-enable word is held for the power manager and driven out as a vector.

Software reaches the four register kinds (enable, polarity, status, wake) through a simple word-wide bus: a write strobe with address and data, and a read data port that reflects the addressed word combinationally. Pins 0 to 31 live in the first bank word of each kind and pins 32 to 63 in a second word placed four bytes above it. Only edges are recognised; a pin held at a steady level never produces an event.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: A status bit is set only by a qualifying transition of its pin; a pin held steadily high or steadily low sets nothing.
- R2: Word addresses are: enable 0x00 (pins 0-31) and 0x04 (pins 32-63), polarity 0x08 and 0x0C, status 0x10 and 0x14, wake 0x18 and 0x1C; pin p sits at bit p mod 32 of its bank word. Enable, polarity and wake read back what was written; bus_rdata_o shows the addressed word in the same cycle.
- R3: A polarity bit of 0 makes its pin detect rising transitions; a bit of 1 makes it detect falling transitions only.
- R4: A detected transition sets the status bit even when the pin's enable bit is 0.
- R5: Writing a word to a status address clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R6: irq_o equals the OR over all pins of (status AND enable) as it stood one clock earlier.
- R7: The wake-enable words are plain read/write masks and drive wake_en_o bit for bit.
- R8: When a transition on a pin is detected in the same cycle as a status write that clears that pin's bit, the bit remains set.
- R9: Reads of any other address (including misaligned ones) return zero, and writes to them change no register.
- R10: Reset clears every register, the synchronisers and irq_o to zero.
- R11: A pin change present before clock edge n sets its status bit at edge n+2 and, if enabled, raises irq_o at edge n+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pins_i | input | NUM_PINS | Asynchronous pin levels |
| bus_addr_i | input | ADDR_W | Byte address of the register word |
| bus_wr_i | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed word |
| irq_o | output | 1 | Registered combined interrupt request |
| wake_en_o | output | NUM_PINS | Per-pin wake-enable mask |

## Verification
A pin level driven between clock edges reaches the status word after the third rising edge and the request output after the fourth, so the bench waits four falling edges after every pin change before reading. Register writes land on the edge inside the write task and are read back at the following falling edge, while the request output, one register later, is checked both at that falling edge (old value) and one cycle on (new value). The same-cycle clear-versus-event case is staged by raising the write strobe exactly in the cycle where the synchronised edge is visible.

// File: rtl/gei_pkg.sv
`timescale 1ns/1ps
package gei_pkg;
   localparam int BANK_W   = 32;
   localparam int MAX_PINS = 64;

   // register kind, taken from byte address bits [4:3]
   typedef enum logic [1:0] {
      KIND_EN   = 2'd0,
      KIND_POL  = 2'd1,
      KIND_STAT = 2'd2,
      KIND_WAKE = 2'd3
   } kind_e;

   function automatic int bank_width(input int pins, input int bank);
      int rest;
      rest = pins - bank * BANK_W;
      return (rest > BANK_W) ? BANK_W : rest;
   endfunction
endpackage

// File: rtl/gei_sync.sv
`timescale 1ns/1ps
module gei_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   localparam int LAST = STAGES - 1;

   logic [W-1:0] stg_q [STAGES];
   logic [W-1:0] prev_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
         prev_q <= '0;
      end else begin
         stg_q[0] <= pin_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
         prev_q <= stg_q[LAST];
      end
   end

   assign rise_o =  stg_q[LAST] & ~prev_q;
   assign fall_o = ~stg_q[LAST] &  prev_q;
endmodule

// File: rtl/gei_bank.sv
`timescale 1ns/1ps
module gei_bank
   import gei_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_i,
   input  kind_e        kind_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] rise_i,
   input  logic [W-1:0] fall_i,
   output logic [W-1:0] en_o,
   output logic [W-1:0] pol_o,
   output logic [W-1:0] stat_o,
   output logic [W-1:0] wake_o,
   output logic [W-1:0] event_o,
   output logic [W-1:0] clr_o
);
   logic [W-1:0] en_q, pol_q, stat_q, wake_q;

   // polarity 0 -> rising, 1 -> falling
   assign event_o = (rise_i & ~pol_q) | (fall_i & pol_q);
   assign clr_o   = (wr_i && kind_i == KIND_STAT) ? wdata_i : '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         en_q   <= '0;
         pol_q  <= '0;
         stat_q <= '0;
         wake_q <= '0;
      end else begin
         if (wr_i && kind_i == KIND_EN)   en_q   <= wdata_i;
         if (wr_i && kind_i == KIND_POL)  pol_q  <= wdata_i;
         if (wr_i && kind_i == KIND_WAKE) wake_q <= wdata_i;
         // a fresh event outranks a clear in the same cycle
         stat_q <= (stat_q & ~clr_o) | event_o;
      end
   end

   assign en_o   = en_q;
   assign pol_o  = pol_q;
   assign stat_o = stat_q;
   assign wake_o = wake_q;
endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_irq_ctrl
   import gei_pkg::*;
#(
   parameter int NUM_PINS    = 64,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic                bus_wr_i,
   input  logic [31:0]         bus_wdata_i,
   output logic [31:0]         bus_rdata_o,
   output logic                irq_o,
   output logic [NUM_PINS-1:0] wake_en_o
);
   localparam int NBANK = (NUM_PINS + BANK_W - 1) / BANK_W;

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..64");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must be at least 6");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // address decode
   kind_e kind;
   logic  bank_idx;
   logic  addr_mapped;

   assign kind     = kind_e'(bus_addr_i[4:3]);
   assign bank_idx = bus_addr_i[2];
   assign addr_mapped = (bus_addr_i[1:0] == 2'b00)
                     && (bus_addr_i[ADDR_W-1:5] == '0)
                     && (32'(bank_idx) < NBANK);

   logic [NUM_PINS-1:0] en_all, pol_all, stat_all, wake_all, event_all, clr_all;
   logic [31:0] en_w [NBANK];
   logic [31:0] pol_w [NBANK];
   logic [31:0] stat_w [NBANK];
   logic [31:0] wake_w [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam int W  = bank_width(NUM_PINS, b);
      localparam int LO = b * BANK_W;

      logic [W-1:0] rise, fall, en, pol, stat, wake, evt, clr;
      logic         wr;

      assign wr = bus_wr_i && addr_mapped && (bank_idx == 1'(b));

      gei_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .pin_i  (pins_i[LO +: W]),
         .rise_o (rise),
         .fall_o (fall)
      );

      gei_bank #(.W(W)) u_bank (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .wr_i    (wr),
         .kind_i  (kind),
         .wdata_i (bus_wdata_i[W-1:0]),
         .rise_i  (rise),
         .fall_i  (fall),
         .en_o    (en),
         .pol_o   (pol),
         .stat_o  (stat),
         .wake_o  (wake),
         .event_o (evt),
         .clr_o   (clr)
      );

      assign en_all[LO +: W]    = en;
      assign pol_all[LO +: W]   = pol;
      assign stat_all[LO +: W]  = stat;
      assign wake_all[LO +: W]  = wake;
      assign event_all[LO +: W] = evt;
      assign clr_all[LO +: W]   = clr;

      assign en_w[b]   = 32'(en);
      assign pol_w[b]  = 32'(pol);
      assign stat_w[b] = 32'(stat);
      assign wake_w[b] = 32'(wake);
   end

   // read mux
   always_comb begin
      bus_rdata_o = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (addr_mapped && bank_idx == 1'(b)) begin
            case (kind)
               KIND_EN:   bus_rdata_o = en_w[b];
               KIND_POL:  bus_rdata_o = pol_w[b];
               KIND_STAT: bus_rdata_o = stat_w[b];
               KIND_WAKE: bus_rdata_o = wake_w[b];
               default:   bus_rdata_o = '0;
            endcase
         end
      end
   end

   // combined request
   logic irq_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |(stat_all & en_all);
   end

   assign irq_o     = irq_q;
   assign wake_en_o = wake_all;
endmodule

// File: rtl/gei_chk.sv
`timescale 1ns/1ps
module gei_chk #(
   parameter int NUM_PINS = 64
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                wr_i,
   input logic                mapped_i,
   input logic [NUM_PINS-1:0] en_i,
   input logic [NUM_PINS-1:0] pol_i,
   input logic [NUM_PINS-1:0] stat_i,
   input logic [NUM_PINS-1:0] wake_i,
   input logic [NUM_PINS-1:0] event_i,
   input logic [NUM_PINS-1:0] clr_i,
   input logic                irq_i
);
   assert_irq_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_i == $past(|(stat_i & en_i))));

   assert_event_latched_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (event_i != '0) |=> ((stat_i & $past(event_i)) == $past(event_i)));

   assert_clear_applies_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i != '0) |=> ((stat_i & $past(clr_i & ~event_i)) == '0));

   assert_no_spurious_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((stat_i & ~$past(stat_i) & ~$past(event_i)) == '0));

   assert_unmapped_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !mapped_i) |=> ($stable(en_i) && $stable(pol_i) && $stable(wake_i)));
endmodule

bind gpio_edge_irq_ctrl gei_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .wr_i     (bus_wr_i),
   .mapped_i (addr_mapped),
   .en_i     (en_all),
   .pol_i    (pol_all),
   .stat_i   (stat_all),
   .wake_i   (wake_all),
   .event_i  (event_all),
   .clr_i    (clr_all),
   .irq_i    (irq_o)
);

// File: tb/sim_gpio_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] pins = '0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic [63:0] wake;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   gpio_edge_irq_ctrl u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .pins_i      (pins),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq),
      .wake_en_o   (wake)
   );

   // {pin[5:0], pol, level_before, level_after, enable, exp_status, exp_irq}
   localparam logic [11:0] VEC [8] = '{
      {6'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
      {6'd5,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {6'd5,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
      {6'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
      {6'd40, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      {6'd40, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
      {6'd63, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      {6'd0,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_word(input logic [7:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic check_all_zero(input string req);
      logic [31:0] v;
      for (int k = 0; k < 8; k++) begin
         rd_word(8'(k * 4), v);
         chk(req, 64'(v), 64'h0);
      end
      chk(req, 64'(irq), 64'h0);
      chk(req, wake, 64'h0);
   endtask

   initial begin
      logic [31:0] v;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      check_all_zero("R10 reset");

      // vector table: polarity, enable masking, steady levels
      for (int i = 0; i < 8; i++) begin
         logic [11:0] e;
         int p;
         logic [7:0] bofs;
         e = VEC[i];
         p = int'(e[11:6]);
         bofs = (p >= 32) ? 8'h04 : 8'h00;
         pins[p] = e[4];
         cyc(4);
         wr_word(8'h08 | bofs, 32'(e[5]) << (p % 32));
         wr_word(8'h00 | bofs, 32'(e[2]) << (p % 32));
         wr_word(8'h10, 32'hFFFF_FFFF);
         wr_word(8'h14, 32'hFFFF_FFFF);
         pins[p] = e[3];
         cyc(4);
         rd_word(8'h10 | bofs, v);
         chk($sformatf("R1 R3 R4 vector %0d status", i), 64'(v[p % 32]), 64'(e[1]));
         chk($sformatf("R6 vector %0d irq", i), 64'(irq), 64'(e[0]));
      end
      pins = '0;
      cyc(4);
      wr_word(8'h00, 0); wr_word(8'h04, 0);
      wr_word(8'h08, 0); wr_word(8'h0C, 0);
      wr_word(8'h10, 32'hFFFF_FFFF); wr_word(8'h14, 32'hFFFF_FFFF);
      cyc(1);

      // R2 / R7 read-back and wake output
      wr_word(8'h04, 32'hA5A5_0F0F);
      rd_word(8'h04, v); chk("R2 enable bank1", 64'(v), 64'hA5A5_0F0F);
      wr_word(8'h0C, 32'hFFFF_0000);
      rd_word(8'h0C, v); chk("R2 polarity bank1", 64'(v), 64'hFFFF_0000);
      wr_word(8'h18, 32'h1234_5678);
      wr_word(8'h1C, 32'h8000_0001);
      rd_word(8'h18, v); chk("R7 wake bank0", 64'(v), 64'h1234_5678);
      chk("R7 wake output", wake, 64'h8000_0001_1234_5678);
      wr_word(8'h04, 0);
      wr_word(8'h0C, 0);

      // R11 latency and R6 timing
      wr_word(8'h00, 32'h0000_0080);
      pins[7] = 1'b1;
      cyc(2);
      rd_word(8'h10, v); chk("R11 status not yet", 64'(v), 64'h0);
      cyc(1);
      rd_word(8'h10, v); chk("R11 status at third edge", 64'(v), 64'h80);
      chk("R11 irq not yet", 64'(irq), 64'h0);
      cyc(1);
      chk("R11 irq at fourth edge", 64'(irq), 64'h1);

      // R5 write-one-to-clear
      pins[3] = 1'b1;
      cyc(4);
      rd_word(8'h10, v); chk("R5 two events", 64'(v), 64'h88);
      wr_word(8'h10, 32'h0);
      rd_word(8'h10, v); chk("R5 zero write keeps", 64'(v), 64'h88);
      wr_word(8'h10, 32'h8);
      rd_word(8'h10, v); chk("R5 one bit cleared", 64'(v), 64'h80);
      wr_word(8'h10, 32'h80);
      chk("R6 irq lags clear", 64'(irq), 64'h1);
      cyc(1);
      chk("R6 irq drops", 64'(irq), 64'h0);

      // R4 event while disabled, then enabling raises irq
      pins[9] = 1'b1;
      cyc(4);
      rd_word(8'h10, v); chk("R4 disabled pin latched", 64'(v), 64'h200);
      chk("R4 no irq while disabled", 64'(irq), 64'h0);
      wr_word(8'h00, 32'h280);
      chk("R6 irq lags enable", 64'(irq), 64'h0);
      cyc(1);
      chk("R6 irq after enable", 64'(irq), 64'h1);

      // R8 event coinciding with clear
      wr_word(8'h00, 32'h0);
      @(negedge clk); pins[12] = 1'b1;
      cyc(2);
      addr = 8'h10; wdata = 32'h1200; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      rd_word(8'h10, v); chk("R8 event survives clear", 64'(v), 64'h1000);

      // R9 unmapped space
      wr_word(8'h20, 32'hFFFF_FFFF);
      wr_word(8'h02, 32'hFFFF_FFFF);
      wr_word(8'h41, 32'hFFFF_FFFF);
      wr_word(8'hE0, 32'hFFFF_FFFF);
      rd_word(8'h00, v); chk("R9 enable untouched", 64'(v), 64'h0);
      rd_word(8'h08, v); chk("R9 polarity untouched", 64'(v), 64'h0);
      chk("R9 wake untouched", wake, 64'h8000_0001_1234_5678);
      rd_word(8'h20, v); chk("R9 read 0x20", 64'(v), 64'h0);
      rd_word(8'h11, v); chk("R9 misaligned status read", 64'(v), 64'h0);
      rd_word(8'hF0, v); chk("R9 read 0xF0", 64'(v), 64'h0);

      // R10 reset mid-run
      wr_word(8'h00, 32'h1000);
      cyc(1);
      chk("R10 irq before reset", 64'(irq), 64'h1);
      rst_n = 1'b0;
      cyc(2);
      pins = '0;
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
      check_all_zero("R10 reset mid-run");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule